// File: doc/BRIEF.md
# Shift Register with Latched Parallel Outputs

This block is a synchronous shift register of `W` stages (four by default) with two ways of filling its stages and a separate output latch. On every rising clock edge a select input chooses between moving the word one stage up, with stage 0 taking a new serial bit, and capturing a whole parallel word at once. The content of the top stage is always visible as the serial output. That output can feed the serial input of another instance to build a longer register, or the block can close its own ring through a mode input.

The parallel outputs do not follow the stages. They come from a holding register that changes only when a clock-sampled strobe goes from low to high. On that edge it captures the stage pattern as it stood before the same edge's shift or load. A reader can therefore take a stable snapshot while the stages keep moving.

Top module: `sr_latched_top`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising clock edge) clears all stages, the holding register and the strobe history to zero, so `ser_out` and `par_out` read 0 after that edge.
- R2: With `shift_sel` high (value 1 = shift) and `ring_en` low, each stage i>0 takes the old value of stage i-1 and stage 0 takes `ser_in`.
- R3: With `shift_sel` low (value 0 = load), stage i takes `par_in[i]`. `ser_in` and `ring_en` have no effect.
- R4: `ser_out` equals the top stage (index W-1) at all times, so a word loaded in parallel leaves through `ser_out` most significant bit first.
- R5: With `shift_sel` high and `ring_en` high, stage 0 takes the old top stage instead of `ser_in`, so W shifts restore the word.
- R6: When `strobe` is sampled high at a clock edge after being sampled low at the previous edge, `par_out` (bit i from stage i) takes the stage values from before that edge and shows them after it.
- R7: At every other edge `par_out` keeps its value, including while `strobe` stays high and while the stages shift or load.
- R8: Two instances with the serial output of the first wired to the serial input of the second, sharing all controls, act as one 2W-bit register whose low half is the first instance.
- R9: A strobe edge that falls on the same clock as a load or shift captures the pre-edge stages, not the newly loaded or shifted ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial bit entering stage 0 when shifting |
| par_in | input | W | Parallel word, bit i for stage i |
| shift_sel | input | 1 | 1 = shift, 0 = parallel load |
| ring_en | input | 1 | 1 = feed the top stage back into stage 0 while shifting |
| strobe | input | 1 | Capture request; its rising edge updates the holding register |
| ser_out | output | 1 | Top stage content |
| par_out | output | W | Holding register content |

## Verification
A strobe rising edge can coincide with a parallel load or with a shift, and both act on the same edge. The bench provokes this by raising `strobe` in the same cycle as a load of a new word and in the same cycle as a shift. It then checks that `par_out` shows the word from before the edge, while `ser_out` already reflects the new stage content. A strobe held high across several shifting cycles is judged separately, to confirm that only the first edge captures.

// File: rtl/sr_pkg.sv
// Package: shared encodings for the latched-output shift register.
// Assumes: nothing beyond IEEE 1800-2017.
package sr_pkg;
    // Meaning of the stage-update select input.
    typedef enum logic {
        SEL_LOAD  = 1'b0,
        SEL_SHIFT = 1'b1
    } sel_e;
endpackage

// File: rtl/sr_stage_chain.sv
// Module: chain of W storage stages that shift up by one or load in parallel.
// Assumes: synchronous active-low reset; W >= 2.
module sr_stage_chain
    import sr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_sel,
    input  logic         ring_en,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] stage_q
);
    localparam int TOP = W - 1;

    logic [W-1:0] stage_d;
    logic         head_bit;
    sel_e         sel;

    // Decode the select input into its named meaning.
    assign sel = sel_e'(shift_sel);

    // Pick the bit entering stage 0: the serial input or the looped-back top stage.
    assign head_bit = ring_en ? stage_q[TOP] : ser_in;

    // Next value of each stage: its predecessor when shifting, its parallel bit when loading.
    for (genvar i = 0; i < W; i++) begin : g_next
        if (i == 0) begin : g_head
            assign stage_d[i] = (sel == SEL_SHIFT) ? head_bit : par_in[i];
        end else begin : g_body
            assign stage_d[i] = (sel == SEL_SHIFT) ? stage_q[i-1] : par_in[i];
        end
    end

    // Register all stages on the rising clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end
endmodule

// File: rtl/sr_rise_det.sv
// Module: clock-sampled rising-edge detector for the capture strobe.
// Assumes: strobe is synchronous to clk; reset clears the history to 0.
module sr_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    // Remember the strobe value from the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Flag a low-to-high change between consecutive samples.
    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/sr_hold_reg.sv
// Module: output holding register that captures a word only on request.
// Assumes: synchronous active-low reset; capture is a one-cycle pulse.
module sr_hold_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Take the presented word on capture, otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/sr_latched_top.sv
// Module: shift register with parallel load, serial output and a strobe-latched parallel output.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module sr_latched_top #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    input  logic         shift_sel,
    input  logic         ring_en,
    input  logic         strobe,
    output logic         ser_out,
    output logic [W-1:0] par_out
);
    logic [W-1:0] stage_q;
    logic         cap_pulse;

    sr_stage_chain #(.W(W)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_sel (shift_sel),
        .ring_en   (ring_en),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .stage_q   (stage_q)
    );

    sr_rise_det u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (cap_pulse)
    );

    // The holding register sees the stages before this edge's update.
    sr_hold_reg #(.W(W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_pulse),
        .d       (stage_q),
        .q       (par_out)
    );

    // Serial output is the top stage.
    assign ser_out = stage_q[W-1];
endmodule

// File: rtl/sr_latched_chk.sv
// Module: property checker for sr_latched_top, attached by bind.
// Assumes: sees the stage vector of the top through the bind connection.
module sr_latched_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ser_in,
    input logic [W-1:0] par_in,
    input logic         shift_sel,
    input logic         ring_en,
    input logic         strobe,
    input logic         ser_out,
    input logic [W-1:0] par_out,
    input logic [W-1:0] stages
);
    // R1: reset clears the stages and the holding register.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (stages == '0 && par_out == '0));

    // R2: a shift moves every stage up by one.
    a_r2_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        shift_sel |=> stages[W-1:1] == $past(stages[W-2:0]));

    // R2: without ring mode stage 0 takes the serial input.
    a_r2_head_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_sel && !ring_en) |=> stages[0] == $past(ser_in));

    // R3: a load copies the parallel word.
    a_r3_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_sel |=> stages == $past(par_in));

    // R5: ring mode feeds the old top stage into stage 0.
    a_r5_ring_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_sel && ring_en) |=> stages[0] == $past(stages[W-1]));

    // R6 and R9: a strobe rise captures the stages from before the edge.
    a_r6_capture_old: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && strobe && !$past(strobe)) |=> par_out == $past(stages));

    // R7: with no strobe rise the holding register keeps its value.
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!strobe || $past(strobe))) |=> $stable(par_out));

    // R4: the serial output follows the top stage one cycle after a load.
    a_r4_serout_load: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_sel |=> ser_out == $past(par_in[W-1]));
endmodule

bind sr_latched_top sr_latched_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .par_in    (par_in),
    .shift_sel (shift_sel),
    .ring_en   (ring_en),
    .strobe    (strobe),
    .ser_out   (ser_out),
    .par_out   (par_out),
    .stages    (stage_q)
);

// File: tb/tb_sr_latched_top.sv
// Bench: vector walk against a reference model, then directed reset, cascade and corner tests.
module tb_sr_latched_top;
    localparam int W = 4;
    localparam int NV = 14;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ser_in, shift_sel, ring_en, strobe;
    logic [W-1:0] par_in;
    logic         ser_out;
    logic [W-1:0] par_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // Reference model state.
    logic [W-1:0] m_st, m_hold;
    logic         m_sq;

    // Vector fields: {shift_sel, ring_en, strobe, ser_in, par_in[3:0]}.
    localparam logic [7:0] VEC [NV] = '{
        8'b0_0_0_0_1010,  // load 1010
        8'b1_0_1_1_0000,  // shift in 1 while strobe rises: capture 1010 (R9)
        8'b1_0_1_0_0000,  // strobe held high: no capture (R7)
        8'b1_0_1_1_0000,
        8'b1_0_0_1_0000,
        8'b1_0_1_0_0000,  // new rise: capture
        8'b1_1_0_1_0000,  // ring shift, ser_in ignored (R5)
        8'b1_1_0_0_0000,
        8'b1_1_1_1_0000,  // ring shift with capture
        8'b0_1_0_1_0110,  // load 0110, ring ignored (R3)
        8'b0_0_1_1_1001,  // load 1001 with capture of 0110 (R9)
        8'b1_1_0_0_0000,
        8'b1_1_0_1_0000,
        8'b1_1_1_0_0000
    };

    sr_latched_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .par_in(par_in),
        .shift_sel(shift_sel), .ring_en(ring_en), .strobe(strobe),
        .ser_out(ser_out), .par_out(par_out)
    );

    // Cascade pair for R8.
    logic         c_ser_in, c_link, c_ser_out;
    logic [W-1:0] c_par_a, c_par_b, c_out_a, c_out_b;

    sr_latched_top #(.W(W)) casc_a (
        .clk(clk), .rst_n(rst_n), .ser_in(c_ser_in), .par_in(c_par_a),
        .shift_sel(shift_sel), .ring_en(1'b0), .strobe(strobe),
        .ser_out(c_link), .par_out(c_out_a)
    );

    sr_latched_top #(.W(W)) casc_b (
        .clk(clk), .rst_n(rst_n), .ser_in(c_link), .par_in(c_par_b),
        .shift_sel(shift_sel), .ring_en(1'b0), .strobe(strobe),
        .ser_out(c_ser_out), .par_out(c_out_b)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, advance one clock, update the model, sample at the next falling edge.
    task automatic step(input logic ss, input logic re, input logic sb, input logic si, input logic [W-1:0] pi);
        shift_sel = ss; ring_en = re; strobe = sb; ser_in = si; par_in = pi;
        @(posedge clk);
        if (!rst_n) begin
            m_st = '0; m_hold = '0; m_sq = 1'b0;
        end else begin
            if (sb && !m_sq) m_hold = m_st;
            m_sq = sb;
            if (ss) m_st = {m_st[W-2:0], (re ? m_st[W-1] : si)};
            else    m_st = pi;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] m8;
        rst_n = 1'b0; shift_sel = 1'b0; ring_en = 1'b0; strobe = 1'b0;
        ser_in = 1'b0; par_in = '0; c_ser_in = 1'b0; c_par_a = '0; c_par_b = '0;
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, 1'b1, 4'hF);
        chk("R1 reset ser_out", {31'd0, ser_out}, 32'd0);
        chk("R1 reset par_out", {28'd0, par_out}, 32'd0);
        rst_n = 1'b1;

        // Vector walk against the model.
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4], VEC[k][3:0]);
            chk(VEC[k][7] ? (VEC[k][6] ? "R5 ser_out ring" : "R2 ser_out shift") : "R3 R4 ser_out load",
                {31'd0, ser_out}, {31'd0, m_st[W-1]});
            chk(VEC[k][5] ? "R6 R9 par_out capture" : "R7 par_out hold",
                {28'd0, par_out}, {28'd0, m_hold});
        end

        // R4: a loaded word leaves MSB first.
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'b1011);
        chk("R4 msb out", {31'd0, ser_out}, 32'd1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000);
        chk("R4 bit2 out", {31'd0, ser_out}, 32'd0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000);
        chk("R4 bit1 out", {31'd0, ser_out}, 32'd1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000);
        chk("R4 bit0 out", {31'd0, ser_out}, 32'd1);

        // R5: four ring shifts restore the word.
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'b1101);
        for (int k = 0; k < W; k++) step(1'b1, 1'b1, 1'b0, 1'b0, 4'b0000);
        step(1'b1, 1'b1, 1'b1, 1'b0, 4'b0000);
        chk("R5 ring restores word", {28'd0, par_out}, 32'hD);

        // R1: reset mid-run with strobe high, then a held strobe does not capture.
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'b0110);
        chk("R1 mid-run reset par_out", {28'd0, par_out}, 32'd0);
        chk("R1 mid-run reset ser_out", {31'd0, ser_out}, 32'd0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'b0110);
        step(1'b1, 1'b0, 1'b1, 1'b1, 4'b0000);
        chk("R9 capture before shift", {28'd0, par_out}, 32'h6);
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'b1111);
        chk("R7 held strobe no capture", {28'd0, par_out}, 32'h6);

        // R8: cascade behaves as one 8-bit register.
        strobe = 1'b0;
        c_par_a = 4'b0011; c_par_b = 4'b1100;
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'b0000);
        m8 = {c_par_b, c_par_a};
        chk("R8 cascade top bit after load", {31'd0, c_ser_out}, {31'd0, m8[2*W-1]});
        for (int k = 0; k < 2 * W; k++) begin
            c_ser_in = k[0];
            step(1'b1, 1'b0, 1'b0, 1'b0, 4'b0000);
            m8 = {m8[2*W-2:0], k[0]};
            chk("R8 cascade serial out", {31'd0, c_ser_out}, {31'd0, m8[2*W-1]});
        end
        step(1'b1, 1'b0, 1'b1, 1'b0, 4'b0000);
        chk("R8 cascade snapshot", {24'd0, c_out_b, c_out_a}, {24'd0, m8});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule